// File: doc/BRIEF.md
# Buffered Period/Duty PWM Generator

This block produces one pulse-width modulated pin from a free-running 8-bit period timer. Software writes an 8-bit period value, an 8-bit upper duty value, a control word that holds the two lowest duty bits and a mode code, and a prescale select. The timer advances once every 4 × prescale input clocks. Two sub-count bits extend it to a 10-bit time base, so the duty resolution is one quarter of a timer step.

The duty value is double-buffered. Writes land in working registers at any time. The comparator only sees a slave copy, and that copy is refreshed each time the timer passes the period value and restarts from zero. At each restart the output goes high. It goes low when the 10-bit time base reaches the slave duty value. The pin is driven only when its direction input selects output. Outside PWM mode the pin carries the ordinary port data bit.

Top module: `pwm_timer_gen`

## Requirements
- R1: After reset, and after entering PWM mode, the timer, prescaler and sub-count start from zero. The PWM output stays low until the first period boundary. That boundary comes exactly (period + 1) × 4 × prescale clocks after the clock edge that captures the mode write.
- R2: One PWM period lasts (period + 1) × 4 × prescale clocks. The prescale select ps_i is coded 0 = divide by 1, 1 = divide by 4, 2 or 3 = divide by 16.
- R3: Within a period the output is high for duty × prescale clocks. duty is the 10-bit value {duty_hi, ctrl_i[5:4]}, with duty_hi as the upper eight bits.
- R4: A duty write during a period does not change that period's pulse. It takes effect from the next period boundary.
- R5: A duty value of 0 keeps the output low for the whole period. Clearing the pulse wins over setting it at the boundary.
- R6: A duty value at or above (period + 1) × 4 never matches the time base, so the output stays high for the whole period.
- R7: pin_oe_o is 1 exactly when dir_i is 0 (output direction).
- R8: PWM mode is active only while the stored mode code ctrl_i[3:0] equals 4'b1100. In any other state, including a control word of all zeros, pin_o follows port_data_i and the PWM state returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| period_we_i | input | 1 | Write strobe for the period register |
| period_i | input | 8 | Period value |
| duty_hi_we_i | input | 1 | Write strobe for the upper duty register |
| duty_hi_i | input | 8 | Upper eight duty bits |
| ctrl_we_i | input | 1 | Write strobe for the control register |
| ctrl_i | input | 6 | [5:4] low duty bits, [3:0] mode code |
| ps_we_i | input | 1 | Write strobe for the prescale select |
| ps_i | input | 2 | Prescale select |
| dir_i | input | 1 | Pin direction, 1 = input |
| port_data_i | input | 1 | Port data latch value used outside PWM mode |
| pin_o | output | 1 | Pin value |
| pin_oe_o | output | 1 | Pin drive enable |

## Verification
The hardest case to reach is a duty write that lands in the middle of a live pulse. The write must not shorten or stretch that pulse, yet it must fully govern the next one. The bench follows the pin sample by sample. It issues the duty write on the third high cycle of a running pulse, then measures that pulse and the following one separately. The edge cases of duty zero and duty equal to the full period count are reached by re-entering PWM mode with fresh settings. The low run before the first set then also checks the start-up alignment.

// File: rtl/pwm_gen_pkg.sv
package pwm_gen_pkg;
  localparam int unsigned SUB_W = 2;
  localparam int unsigned PRE_W = 4;
  localparam logic [3:0] MODE_PWM = 4'b1100;

  typedef enum logic [1:0] {
    PS_DIV1   = 2'd0,
    PS_DIV4   = 2'd1,
    PS_DIV16  = 2'd2,
    PS_DIV16B = 2'd3
  } ps_sel_e;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
  import pwm_gen_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  ps_sel_e          ps_sel_i,
  output logic             tick_o,
  output logic [SUB_W-1:0] sub_nxt_o
);
  logic [1:0]       phase_q, phase_d;
  logic [PRE_W-1:0] pre_q, pre_d, pre_lim;
  logic             phase_wrap, pre_at_lim;

  always_comb begin
    unique case (ps_sel_i)
      PS_DIV1: pre_lim = '0;
      PS_DIV4: pre_lim = PRE_W'(3);
      default: pre_lim = '1;
    endcase
  end

  assign phase_wrap = (phase_q == 2'd3);
  // >= so a prescale change mid-count cannot strand the counter above its limit
  assign pre_at_lim = (pre_q >= pre_lim);
  assign tick_o     = en_i && phase_wrap && pre_at_lim;

  always_comb begin
    phase_d = en_i ? phase_q + 2'd1 : 2'd0;
    if (!en_i)           pre_d = '0;
    else if (phase_wrap) pre_d = pre_at_lim ? '0 : pre_q + PRE_W'(1);
    else                 pre_d = pre_q;
  end

  // sub-count bits: quarter-step position inside one timer increment
  always_comb begin
    unique case (ps_sel_i)
      PS_DIV1: sub_nxt_o = phase_d;
      PS_DIV4: sub_nxt_o = pre_d[1:0];
      default: sub_nxt_o = pre_d[3:2];
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      pre_q   <= '0;
    end else begin
      phase_q <= phase_d;
      pre_q   <= pre_d;
    end
  end
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int unsigned TMR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic [TMR_W-1:0] period_i,
  output logic [TMR_W-1:0] timer_q_o,
  output logic [TMR_W-1:0] timer_nxt_o,
  output logic             roll_o
);
  logic [TMR_W-1:0] timer_q;

  assign roll_o = en_i && tick_i && (timer_q == period_i);

  always_comb begin
    if (!en_i)       timer_nxt_o = '0;
    else if (roll_o) timer_nxt_o = '0;
    else if (tick_i) timer_nxt_o = timer_q + TMR_W'(1);
    else             timer_nxt_o = timer_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) timer_q <= '0;
    else         timer_q <= timer_nxt_o;
  end

  assign timer_q_o = timer_q;
endmodule

// File: rtl/pwm_duty_ctl.sv
module pwm_duty_ctl #(
  parameter int unsigned DUTY_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              roll_i,
  input  logic [DUTY_W-1:0] tb_nxt_i,
  input  logic [DUTY_W-1:0] master_i,
  output logic [DUTY_W-1:0] slave_o,
  output logic              pwm_o
);
  logic [DUTY_W-1:0] slave_q, slave_d;
  logic              pwm_q, pwm_d;

  always_comb begin
    slave_d = slave_q;
    pwm_d   = pwm_q;
    if (!en_i) begin
      slave_d = '0;
      pwm_d   = 1'b0;
    end else if (roll_i) begin
      slave_d = master_i;
      // reset beats set: a zero duty matches time base 0 at once
      pwm_d   = (master_i != '0);
    end else if (tb_nxt_i == slave_q) begin
      pwm_d   = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slave_q <= '0;
      pwm_q   <= 1'b0;
    end else begin
      slave_q <= slave_d;
      pwm_q   <= pwm_d;
    end
  end

  assign slave_o = slave_q;
  assign pwm_o   = pwm_q;
endmodule

// File: rtl/pwm_timer_gen.sv
module pwm_timer_gen
  import pwm_gen_pkg::*;
#(
  parameter int unsigned TMR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             period_we_i,
  input  logic [TMR_W-1:0] period_i,
  input  logic             duty_hi_we_i,
  input  logic [TMR_W-1:0] duty_hi_i,
  input  logic             ctrl_we_i,
  input  logic [5:0]       ctrl_i,
  input  logic             ps_we_i,
  input  logic [1:0]       ps_i,
  input  logic             dir_i,
  input  logic             port_data_i,
  output logic             pin_o,
  output logic             pin_oe_o
);
  localparam int unsigned DUTY_W = TMR_W + SUB_W;

  logic [TMR_W-1:0]  period_q, duty_hi_q, timer_q, timer_nxt;
  logic [SUB_W-1:0]  duty_lo_q, sub_nxt;
  logic [3:0]        mode_q;
  ps_sel_e           ps_q;
  logic              pwm_en, tick, roll, pwm_q;
  logic [DUTY_W-1:0] master, slave;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      period_q  <= '0;
      duty_hi_q <= '0;
      duty_lo_q <= '0;
      mode_q    <= '0;
      ps_q      <= PS_DIV1;
    end else begin
      if (period_we_i)  period_q  <= period_i;
      if (duty_hi_we_i) duty_hi_q <= duty_hi_i;
      if (ctrl_we_i) begin
        duty_lo_q <= ctrl_i[5:4];
        mode_q    <= ctrl_i[3:0];
      end
      if (ps_we_i) ps_q <= ps_sel_e'(ps_i);
    end
  end

  assign pwm_en = (mode_q == MODE_PWM);
  assign master = {duty_hi_q, duty_lo_q};

  pwm_prescaler u_pre (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (pwm_en),
    .ps_sel_i  (ps_q),
    .tick_o    (tick),
    .sub_nxt_o (sub_nxt)
  );

  pwm_timebase #(.TMR_W(TMR_W)) u_tb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (pwm_en),
    .tick_i      (tick),
    .period_i    (period_q),
    .timer_q_o   (timer_q),
    .timer_nxt_o (timer_nxt),
    .roll_o      (roll)
  );

  pwm_duty_ctl #(.DUTY_W(DUTY_W)) u_duty (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (pwm_en),
    .roll_i   (roll),
    .tb_nxt_i ({timer_nxt, sub_nxt}),
    .master_i (master),
    .slave_o  (slave),
    .pwm_o    (pwm_q)
  );

  assign pin_o    = pwm_en ? pwm_q : port_data_i;
  assign pin_oe_o = ~dir_i;
endmodule

// File: rtl/pwm_timer_gen_chk.sv
module pwm_timer_gen_chk #(
  parameter int unsigned TMR_W  = 8,
  parameter int unsigned DUTY_W = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pwm_en,
  input logic              roll,
  input logic [TMR_W-1:0]  timer_q,
  input logic [DUTY_W-1:0] master,
  input logic [DUTY_W-1:0] slave,
  input logic              pwm_q
);
  p_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwm_en |=> (!pwm_q && timer_q == '0));

  p_roll_restart_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    roll |=> (timer_q == '0 && slave == $past(master)));

  p_rise_at_roll_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwm_q) |-> $past(roll));

  p_slave_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwm_en && !roll) |=> $stable(slave));

  p_zero_duty_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (roll && master == '0) |=> !pwm_q);

  p_set_nonzero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (roll && master != '0) |=> pwm_q);
endmodule

bind pwm_timer_gen pwm_timer_gen_chk #(.TMR_W(TMR_W), .DUTY_W(DUTY_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .pwm_en  (pwm_en),
  .roll    (roll),
  .timer_q (timer_q),
  .master  (master),
  .slave   (slave),
  .pwm_q   (pwm_q)
);

// File: tb/pwm_timer_gen_tb.sv
`timescale 1ns/1ps
module pwm_timer_gen_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       period_we = 1'b0, duty_hi_we = 1'b0, ctrl_we = 1'b0, ps_we = 1'b0;
  logic [7:0] period = '0, duty_hi = '0;
  logic [5:0] ctrl = '0;
  logic [1:0] ps = '0;
  logic       dir = 1'b1, port_data = 1'b0;
  logic       pin, oe;
  int         n_run = 0, n_fail = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  pwm_timer_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .period_we_i(period_we), .period_i(period),
    .duty_hi_we_i(duty_hi_we), .duty_hi_i(duty_hi),
    .ctrl_we_i(ctrl_we), .ctrl_i(ctrl),
    .ps_we_i(ps_we), .ps_i(ps),
    .dir_i(dir), .port_data_i(port_data),
    .pin_o(pin), .pin_oe_o(oe)
  );

  task automatic check(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic setup(logic [7:0] pr, logic [1:0] p, logic [7:0] dh, logic [1:0] dl);
    @(negedge clk);
    ctrl = {dl, 4'b0000}; ctrl_we = 1'b1;
    period = pr; period_we = 1'b1;
    duty_hi = dh; duty_hi_we = 1'b1;
    ps = p; ps_we = 1'b1;
    @(negedge clk);
    ctrl_we = 1'b0; period_we = 1'b0; duty_hi_we = 1'b0; ps_we = 1'b0;
  endtask

  task automatic write_ctrl(logic [5:0] v);
    @(negedge clk);
    ctrl = v; ctrl_we = 1'b1;
    @(negedge clk);
    ctrl_we = 1'b0; #1;
  endtask

  // returns number of low samples before the first high one
  task automatic low_run(output int n);
    n = 0;
    while (!pin && n < 5000) begin n++; step(); end
  endtask

  task automatic measure(output int hi, output int per);
    int g = 0;
    int lo = 0;
    hi = 0;
    while (pin && g < 5000) begin g++; step(); end
    while (!pin && g < 10000) begin g++; step(); end
    while (pin && hi < 5000) begin hi++; step(); end
    while (!pin && lo < 5000) begin lo++; step(); end
    per = hi + lo;
  endtask

  task automatic t_reset();
    int v;
    step();
    check("R8 reset pin follows port 0", int'(pin), 0);
    port_data = 1'b1; #1;
    check("R8 reset pin follows port 1", int'(pin), 1);
    port_data = 1'b0;
    dir = 1'b1; #1;
    check("R7 oe off for input", int'(oe), 0);
    dir = 1'b0; #1;
    check("R7 oe on for output", int'(oe), 1);
    v = 0;
    for (int i = 0; i < 30; i++) begin step(); if (pin) v++; end
    check("R1 idle after reset stays low", v, 0);
  endtask

  task automatic t_basic();
    int n, hi, per;
    setup(8'd4, 2'd0, 8'd1, 2'd2);
    write_ctrl({2'd2, 4'b1100});
    low_run(n);
    check("R1 low until first boundary", n, 20);
    measure(hi, per);
    check("R3 high time duty 6 div1", hi, 6);
    check("R2 period pr 4 div1", per, 20);
    write_ctrl(6'd0);
  endtask

  task automatic t_presc();
    int n, hi, per;
    setup(8'd4, 2'd1, 8'd1, 2'd2);
    write_ctrl({2'd2, 4'b1100});
    low_run(n);
    check("R1 first boundary div4", n, 80);
    measure(hi, per);
    check("R3 high time duty 6 div4", hi, 24);
    check("R2 period pr 4 div4", per, 80);
    write_ctrl(6'd0);
    setup(8'd2, 2'd2, 8'd1, 2'd1);
    write_ctrl({2'd1, 4'b1100});
    measure(hi, per);
    check("R3 high time duty 5 div16", hi, 80);
    check("R2 period pr 2 div16", per, 192);
    write_ctrl(6'd0);
  endtask

  task automatic t_buffer();
    int hi, hi2, g;
    setup(8'd9, 2'd0, 8'd2, 2'd2);
    write_ctrl({2'd2, 4'b1100});
    g = 0;
    while (!pin && g < 5000) begin g++; step(); end
    hi = 0;
    while (pin && hi < 5000) begin
      hi++;
      if (hi == 3) begin duty_hi = 8'd5; duty_hi_we = 1'b1; end
      else duty_hi_we = 1'b0;
      step();
    end
    duty_hi_we = 1'b0;
    check("R4 running pulse keeps old duty", hi, 10);
    while (!pin && g < 10000) begin g++; step(); end
    hi2 = 0;
    while (pin && hi2 < 5000) begin hi2++; step(); end
    check("R4 next pulse uses new duty", hi2, 22);
    write_ctrl(6'd0);
  endtask

  task automatic t_zero();
    int v = 0;
    setup(8'd3, 2'd0, 8'd0, 2'd0);
    write_ctrl({2'd0, 4'b1100});
    for (int i = 0; i < 100; i++) begin if (pin) v++; step(); end
    check("R5 zero duty never high", v, 0);
    write_ctrl(6'd0);
  endtask

  task automatic t_full();
    int n, v, hi, per;
    setup(8'd3, 2'd0, 8'd4, 2'd0);
    write_ctrl({2'd0, 4'b1100});
    low_run(n);
    check("R1 first boundary pr 3", n, 16);
    v = 0;
    for (int i = 0; i < 64; i++) begin if (!pin) v++; step(); end
    check("R6 duty 16 stays high", v, 0);
    write_ctrl(6'd0);
    setup(8'd3, 2'd0, 8'd3, 2'd3);
    write_ctrl({2'd3, 4'b1100});
    measure(hi, per);
    check("R6 duty 15 one below full", hi, 15);
    check("R2 period pr 3", per, 16);
  endtask

  task automatic t_exit();
    int n, g = 0;
    while (!pin && g < 5000) begin g++; step(); end
    port_data = 1'b1;
    write_ctrl(6'd0);
    check("R8 exit pin follows port 1", int'(pin), 1);
    port_data = 1'b0; #1;
    check("R8 exit pin follows port 0", int'(pin), 0);
    write_ctrl({2'd3, 4'b1000});
    port_data = 1'b1;
    for (int i = 0; i < 40; i++) step();
    check("R8 other mode code keeps port", int'(pin), 1);
    port_data = 1'b0;
    write_ctrl({2'd3, 4'b1100});
    low_run(n);
    check("R1 re-entry restarts from zero", n, 16);
    write_ctrl(6'd0);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_presc();
    t_buffer();
    t_zero();
    t_full();
    t_exit();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule